// File: doc/BRIEF.md
# Round-Robin Switch Allocator with Sticky Connections

This block is the central allocator of a crossbar switch. Every input port has several virtual-channel FIFOs, and the flit at the head of each FIFO is a requester. Each requester names the output port it wants and whether it is the last flit of its message. The allocator decides which head flits cross the crossbar and returns one grant bit per requester. A FIFO pops its head flit when its grant bit is set.

Messages carry no priority, so each output port settles contention with its own round-robin pointer. A message that wins an output keeps a connection to it. That connection is granted every cycle without arbitration while the message keeps flowing. It is dropped after the tail flit crosses, when downstream space runs out, or when the FIFO bubbles.

When a connection is dropped, both the input port and the output port become free. The allocator is pipelined over two clock edges: inputs are registered, then allocation is computed and the grants are registered. Outputs that the bypass path currently holds are masked from new grants.

Top module: `rr_cont_arbiter`

## Requirements
- R1: A grant appears on `gnt_o` exactly two rising clock edges after the request that caused it was presented. All of `req_vld_i`, `req_dst_i`, `req_tail_i`, `out_space_i` and `out_byp_i` are sampled at the first of those edges. Requester r is VC (r mod NUM_VCS) of input port (r div NUM_VCS), and grant bit r belongs to it.
- R2: Each output keeps a round-robin pointer, which is 0 after reset. A new grant goes to the first eligible requester at or after the pointer index, wrapping around. After a new grant to requester r, the pointer becomes (r+1) mod the number of requesters.
- R3: At most one requester per input port is granted in a cycle. A requester whose input port holds a connection at the start of the cycle gets no new grant. Outputs are allocated in ascending index order, and an input port already granted by a lower output this cycle is skipped.
- R4: While a connection exists, its requester is granted every cycle in which it requests, names the same output (field `req_dst_i[r*DW +: DW]`) and that output has `out_space_i` high. No other requester is granted that output.
- R5: If a connected requester stops requesting (a bubble) or its output loses downstream space, it gets no grant that cycle and the connection is released. The freed output and input port can be claimed by new grants from the next cycle on.
- R6: A connection is released after a granted flit with `req_tail_i` high. A new grant to a flit with `req_tail_i` high creates no connection.
- R7: A free output gives a new grant only when its `out_space_i` is high and its `out_byp_i` is low.
- R8: Reset clears all grants, connections and pointers, asynchronously and at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | NUM_PORTS*NUM_VCS | Head flit present, one bit per FIFO |
| req_dst_i | input | NUM_PORTS*NUM_VCS*DW | Requested output port per FIFO, DW = clog2(NUM_PORTS) |
| req_tail_i | input | NUM_PORTS*NUM_VCS | Head flit is the last flit of its message |
| out_space_i | input | NUM_PORTS | Downstream space available per output |
| out_byp_i | input | NUM_PORTS | Output currently held by the bypass path |
| gnt_o | output | NUM_PORTS*NUM_VCS | Pop grant per FIFO, grouped by input port |

## Verification
The bench checks that a competitor asking for a held output is refused until the holder's tail has crossed. A design without stickiness would hand that output over early. It checks that a space loss or a bubble frees the output, and that a later claim goes by round robin rather than back to the interrupted message. It checks that two VCs of one input port are never granted together, even when they target different outputs. A greedy design with no port check would grant both. It also checks that bypass-held or full outputs give nothing, that the grant lags the request by exactly two edges, and that a reset in mid-connection leaves no stale connection behind.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rrc_in_stage.sv
module rrc_in_stage #(
  parameter int unsigned NR = 8,
  parameter int unsigned DW = 2,
  parameter int unsigned P  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NR-1:0]    req_i,
  input  logic [NR*DW-1:0] dst_i,
  input  logic [NR-1:0]    tail_i,
  input  logic [P-1:0]     space_i,
  input  logic [P-1:0]     byp_i,
  output logic [NR-1:0]    req_o,
  output logic [NR*DW-1:0] dst_o,
  output logic [NR-1:0]    tail_o,
  output logic [P-1:0]     space_o,
  output logic [P-1:0]     byp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= '0;
      dst_o   <= '0;
      tail_o  <= '0;
      space_o <= '0;
      byp_o   <= '0;
    end else begin
      req_o   <= req_i;
      dst_o   <= dst_i;
      tail_o  <= tail_i;
      space_o <= space_i;
      byp_o   <= byp_i;
    end
  end
endmodule

// File: rtl/rrc_out_ctl.sv
module rrc_out_ctl
  import rrc_pkg::*;
#(
  parameter int unsigned NR = 8,
  parameter int unsigned V  = 2,
  parameter int unsigned P  = 4,
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NR-1:0] want_i,
  input  logic [NR-1:0] tail_i,
  input  logic          space_i,
  input  logic          byp_i,
  input  logic [P-1:0]  busy_port_i,
  input  logic [P-1:0]  taken_i,
  output logic [NR-1:0] gnt_o,
  output logic [P-1:0]  taken_o,
  output logic          conn_vld_o,
  output logic [SW-1:0] conn_src_o
);
  logic          conn_vld_q;
  logic [SW-1:0] conn_src_q;
  logic [SW-1:0] ptr_q;
  logic [NR-1:0] elig;
  logic          found;
  logic [SW-1:0] pick;
  logic          hold_ok;
  logic          new_gnt;

  for (genvar r = 0; r < NR; r++) begin : g_elig
    assign elig[r] = want_i[r] && !busy_port_i[r/V] && !taken_i[r/V];
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NR; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= int'(NR)) idx = idx - int'(NR);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = SW'(idx);
      end
    end
  end

  assign hold_ok = conn_vld_q && want_i[conn_src_q] && space_i;
  assign new_gnt = !conn_vld_q && space_i && !byp_i && found;

  always_comb begin
    gnt_o = '0;
    if (hold_ok)      gnt_o[conn_src_q] = 1'b1;
    else if (new_gnt) gnt_o[pick] = 1'b1;
  end

  for (genvar p = 0; p < P; p++) begin : g_taken
    assign taken_o[p] = taken_i[p] | (new_gnt && (int'(pick) / int'(V) == p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_vld_q <= 1'b0;
      conn_src_q <= '0;
      ptr_q      <= '0;
    end else if (conn_vld_q) begin
      if (!hold_ok || tail_i[conn_src_q]) conn_vld_q <= 1'b0;
    end else if (new_gnt) begin
      ptr_q <= SW'(wrap_inc(int'(pick), NR));
      if (!tail_i[pick]) begin
        conn_vld_q <= 1'b1;
        conn_src_q <= pick;
      end
    end
  end

  assign conn_vld_o = conn_vld_q;
  assign conn_src_o = conn_src_q;

  assert_sticky_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_vld_q && $past(conn_vld_q)) |-> $stable(conn_src_q));

  assert_break_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_vld_q && !gnt_o[conn_src_q]) |=> !conn_vld_q);

  assert_tail_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_vld_q && gnt_o[conn_src_q] && tail_i[conn_src_q]) |=> !conn_vld_q);

  assert_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conn_vld_q && (byp_i || !space_i)) |-> (gnt_o == '0));
endmodule

// File: rtl/rr_cont_arbiter.sv
module rr_cont_arbiter #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned NUM_VCS   = 2,
  localparam int unsigned NR = NUM_PORTS * NUM_VCS,
  localparam int unsigned DW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned SW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NR-1:0]    req_vld_i,
  input  logic [NR*DW-1:0] req_dst_i,
  input  logic [NR-1:0]    req_tail_i,
  input  logic [NUM_PORTS-1:0] out_space_i,
  input  logic [NUM_PORTS-1:0] out_byp_i,
  output logic [NR-1:0]    gnt_o
);
  localparam int unsigned P = NUM_PORTS;
  localparam int unsigned V = NUM_VCS;

  logic [NR-1:0]    req_q, tail_q;
  logic [NR*DW-1:0] dst_q;
  logic [P-1:0]     space_q, byp_q;
  logic [NR-1:0]    want   [P];
  logic [NR-1:0]    ogn    [P];
  logic [P-1:0]     taken  [P+1];
  logic [P-1:0]     conn_vld;
  logic [SW-1:0]    conn_src [P];
  logic [P-1:0]     busy_port;
  logic [NR-1:0]    gnt_d, gnt_q;

  rrc_in_stage #(.NR(NR), .DW(DW), .P(P)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_vld_i), .dst_i(req_dst_i), .tail_i(req_tail_i),
    .space_i(out_space_i), .byp_i(out_byp_i),
    .req_o(req_q), .dst_o(dst_q), .tail_o(tail_q),
    .space_o(space_q), .byp_o(byp_q)
  );

  for (genvar o = 0; o < P; o++) begin : g_want
    for (genvar r = 0; r < NR; r++) begin : g_req
      assign want[o][r] = req_q[r] && (dst_q[r*DW +: DW] == DW'(o));
    end
  end

  // input ports held by a connection at cycle start
  always_comb begin
    busy_port = '0;
    for (int o = 0; o < P; o++) begin
      if (conn_vld[o]) busy_port[int'(conn_src[o]) / int'(V)] = 1'b1;
    end
  end

  assign taken[0] = '0;

  for (genvar o = 0; o < P; o++) begin : g_out
    rrc_out_ctl #(.NR(NR), .V(V), .P(P), .SW(SW)) u_oc (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .want_i(want[o]), .tail_i(tail_q),
      .space_i(space_q[o]), .byp_i(byp_q[o]),
      .busy_port_i(busy_port), .taken_i(taken[o]),
      .gnt_o(ogn[o]), .taken_o(taken[o+1]),
      .conn_vld_o(conn_vld[o]), .conn_src_o(conn_src[o])
    );
  end

  always_comb begin
    gnt_d = '0;
    for (int o = 0; o < P; o++) gnt_d = gnt_d | ogn[o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  for (genvar p = 0; p < P; p++) begin : g_chk_port
    assert_one_per_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o[p*V +: V]));
  end

  for (genvar r = 0; r < NR; r++) begin : g_chk_req
    assert_gnt_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[r] |-> $past(req_vld_i[r], 2));
  end
endmodule

// File: tb/rr_cont_arbiter_test.sv
`timescale 1ns/1ps
module rr_cont_arbiter_test;
  localparam int NP = 2;
  localparam int NV = 2;
  localparam int N  = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_vld, req_dst, req_tail, gnt;
  logic [1:0] space, byp;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rr_cont_arbiter #(.NUM_PORTS(NP), .NUM_VCS(NV)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_vld_i(req_vld), .req_dst_i(req_dst), .req_tail_i(req_tail),
    .out_space_i(space), .out_byp_i(byp), .gnt_o(gnt)
  );

  // {req, dst, tail, space, byp, expected grant}; bit r = requester r
  localparam logic [19:0] VEC [N] = '{
    {4'b0000, 4'b0000, 4'b0000, 2'b11, 2'b00, 4'b0000},
    {4'b0001, 4'b0000, 4'b0000, 2'b11, 2'b00, 4'b0001},
    {4'b0101, 4'b0000, 4'b0000, 2'b11, 2'b00, 4'b0001},
    {4'b0101, 4'b0000, 4'b0001, 2'b11, 2'b00, 4'b0001},
    {4'b0101, 4'b0000, 4'b0000, 2'b11, 2'b00, 4'b0100},
    {4'b0101, 4'b0000, 4'b0000, 2'b10, 2'b00, 4'b0000},
    {4'b0101, 4'b0000, 4'b0000, 2'b11, 2'b00, 4'b0001},
    {4'b1100, 4'b1000, 4'b0000, 2'b11, 2'b00, 4'b1000},
    {4'b1101, 4'b1000, 4'b1001, 2'b11, 2'b00, 4'b1001},
    {4'b0110, 4'b0000, 4'b0000, 2'b11, 2'b01, 4'b0000},
    {4'b1011, 4'b1010, 4'b1001, 2'b11, 2'b00, 4'b1001},
    {4'b0010, 4'b0010, 4'b0000, 2'b01, 2'b00, 4'b0000}
  };
  string TAGS [N] = '{
    "R1 idle", "R2 first claim", "R4 holder keeps output", "R6 tail crosses",
    "R2 round-robin past r0", "R5 space loss breaks", "R5 R2 re-claim",
    "R5 bubble breaks", "R3 busy port skipped", "R7 bypass mask",
    "R3 one grant per port", "R7 no space"
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] v);
    req_vld  = v[19:16];
    req_dst  = v[15:12];
    req_tail = v[11:8];
    space    = v[7:6];
    byp      = v[5:4];
  endtask

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    check(gnt, 4'b0000, "R8 reset state");
    rst_ni = 1'b1;

    for (int j = 0; j < N + 2; j++) begin
      @(negedge clk);
      if (j >= 2) check(gnt, VEC[j-2][3:0], TAGS[j-2]);
      if (j < N) drive(VEC[j]);
      else       drive({16'h0, 4'h0});
    end

    // latency: r1 asks for output 1
    @(negedge clk);
    drive({4'b0010, 4'b0010, 4'b0000, 2'b11, 2'b00, 4'b0000});
    @(negedge clk);
    check(gnt, 4'b0000, "R1 no grant after one edge");
    @(negedge clk);
    check(gnt, 4'b0010, "R1 grant after two edges");

    // reset while r1 holds output 1
    rst_ni = 1'b0;
    #1;
    check(gnt, 4'b0000, "R8 async reset clears grants");
    @(negedge clk);
    rst_ni = 1'b1;
    drive({4'b0011, 4'b0011, 4'b0000, 2'b11, 2'b00, 4'b0000});
    @(negedge clk);
    @(negedge clk);
    check(gnt, 4'b0001, "R8 connection and pointer cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule